// File: doc/BRIEF.md
# Sync Pin Mode Detector with Spread-Spectrum Offset Generator

This block looks at a single synchronisation pin and decides how a switching regulator's oscillator should run. A pin held low selects the internal oscillator at a fixed frequency. A pin held high selects the internal oscillator with spread spectrum. A pin toggling at a rate inside the accepted band selects external synchronisation, and spread spectrum is then forced off. The rate is judged by counting rising edges of the resynchronised pin over a fixed window of reference-clock cycles.

When the external clock disappears, the fallback depends on the level at which the pin rests. A low pin returns to fixed internal operation at the end of the window that sees the loss. A high pin keeps spread off for a hold time, and only then enables it. While spread is enabled, the block produces a signed period offset that follows a triangle wave. The triangle peaks at ±3 % of the nominal period code and repeats once per modulation period. Downstream logic adds this offset to the nominal period.

Top module: `sync_ss_sel`

## Requirements
- R1: After reset the block is in fixed internal mode: `ext_sync_o`=0, `spread_en_o`=0, `offset_o`=0.
- R2: When the count of rising pin edges in a window of `WIN_CYC` reference cycles is outside [`MIN_EDGES`,`MAX_EDGES`] and the pin is low at window end, the block is in fixed internal mode (`ext_sync_o`=0, `spread_en_o`=0).
- R3: Under the same out-of-range condition with the pin high at window end, coming from fixed or spread internal mode, the block enters spread mode (`ext_sync_o`=0, `spread_en_o`=1).
- R4: A window count inside [`MIN_EDGES`,`MAX_EDGES`] selects external mode (`ext_sync_o`=1, `spread_en_o`=0). `ext_sync_o` only rises one cycle after a window end.
- R5: Pin rates that give too many edges per window (above about 2.2 MHz) never select external mode.
- R6: When the external clock stops with the pin low, the block returns to fixed internal mode at the next window end, with spread off.
- R7: When the external clock stops with the pin high, `ext_sync_o` drops and `spread_en_o` stays 0 for `HOLD_CYC` cycles before it rises. `spread_en_o` never rises directly out of external mode.
- R8: While `spread_en_o` is 0, `offset_o` is 0 from the next cycle on.
- R9: While spread is on, `offset_o` = trunc(`period_i`·3·t / (100·Q)), with Q = `STEPS`/4 and t a triangle index in [−Q, Q]. Its peaks are ±trunc(3·`period_i`/100).
- R10: The triangle advances one step every `MOD_CYC`/`STEPS` cycles and repeats every `MOD_CYC` cycles: 0 up to +Q, down to −Q, back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sync_i | input | 1 | Asynchronous synchronisation pin |
| period_i | input | PW | Nominal period code |
| ext_sync_o | output | 1 | External synchronisation mode selected |
| spread_en_o | output | 1 | Spread spectrum enabled |
| offset_o | output | PW | Signed period offset, two's complement |

## Verification
A wrong mode state shows at the ports within one measurement window as the wrong pair of `ext_sync_o` and `spread_en_o`. The exception is the high-rest fallback, whose fault only becomes visible at the end of the hold time, so the bench samples it both just before and just after that point. A corrupted triangle phase or scaling shows in `offset_o` within one modulation period: as wrong peak values, a nonzero offset while spread is off, or a wrong spacing between peaks.

// File: rtl/sync_ss_pkg.sv
package sync_ss_pkg;
  typedef enum logic [1:0] {
    ST_FIXED = 2'd0,
    ST_SPREAD = 2'd1,
    ST_EXT = 2'd2,
    ST_HOLD = 2'd3
  } sync_state_e;
endpackage

// File: rtl/sync_rate_meter.sv
module sync_rate_meter #(
  parameter int WIN_CYC   = 2000,
  parameter int MIN_EDGES = 4,
  parameter int MAX_EDGES = 36
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic level_o,
  output logic win_done_o,
  output logic win_ok_o
);
  localparam int WW = $clog2(WIN_CYC);
  localparam int EW = $clog2(MAX_EDGES + 2);
  localparam logic [EW-1:0] SAT = EW'(MAX_EDGES + 1);

  logic [2:0]    pin_q;
  logic [WW-1:0] win_cnt;
  logic [EW-1:0] edge_cnt;
  logic          rise, win_end;

  assign rise    = pin_q[1] & ~pin_q[2];
  assign win_end = (win_cnt == WW'(WIN_CYC - 1));
  assign level_o = pin_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q      <= '0;
      win_cnt    <= '0;
      edge_cnt   <= '0;
      win_done_o <= 1'b0;
      win_ok_o   <= 1'b0;
    end else begin
      pin_q      <= {pin_q[1:0], sync_i};
      win_done_o <= win_end;
      if (win_end) begin
        win_cnt  <= '0;
        edge_cnt <= rise ? EW'(1) : '0;
        win_ok_o <= (edge_cnt >= EW'(MIN_EDGES)) && (edge_cnt <= EW'(MAX_EDGES));
      end else begin
        win_cnt <= win_cnt + WW'(1);
        if (rise && edge_cnt != SAT) edge_cnt <= edge_cnt + EW'(1);
      end
    end
  end
endmodule

// File: rtl/sync_mode_ctrl.sv
module sync_mode_ctrl
  import sync_ss_pkg::*;
#(
  parameter int HOLD_CYC = 32000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  input  logic win_done_i,
  input  logic win_ok_i,
  output logic ext_o,
  output logic spread_o
);
  localparam int HW = $clog2(HOLD_CYC + 1);

  sync_state_e   st_q, st_d;
  logic [HW-1:0] hold_cnt;
  logic          hold_end;

  assign hold_end = (hold_cnt == HW'(HOLD_CYC - 1));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_FIXED, ST_SPREAD:
        if (win_done_i) st_d = win_ok_i ? ST_EXT : (level_i ? ST_SPREAD : ST_FIXED);
      ST_EXT:
        if (win_done_i && !win_ok_i) st_d = level_i ? ST_HOLD : ST_FIXED;
      ST_HOLD:
        if (win_done_i && win_ok_i) st_d = ST_EXT;
        else if (!level_i)          st_d = ST_FIXED;
        else if (hold_end)          st_d = ST_SPREAD;
      default: st_d = ST_FIXED;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_FIXED;
      hold_cnt <= '0;
    end else begin
      st_q     <= st_d;
      hold_cnt <= (st_q == ST_HOLD && !hold_end) ? hold_cnt + HW'(1) : '0;
    end
  end

  assign ext_o    = (st_q == ST_EXT);
  assign spread_o = (st_q == ST_SPREAD);
endmodule

// File: rtl/spread_tri_gen.sv
module spread_tri_gen #(
  parameter int PW      = 12,
  parameter int MOD_CYC = 125000,
  parameter int STEPS   = 100
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic [PW-1:0]        period_i,
  output logic signed [PW-1:0] offset_o
);
  localparam int STEP_CYC = MOD_CYC / STEPS;
  localparam int SW       = $clog2(STEP_CYC + 1);
  localparam int PWD      = $clog2(STEPS);
  localparam int Q        = STEPS / 4;
  localparam int DEN      = 100 * Q;

  logic [SW-1:0]  step_cnt;
  logic [PWD-1:0] phase;
  logic           step_end, phase_end;
  int             tri_v, off_v;

  assign step_end  = (step_cnt == SW'(STEP_CYC - 1));
  assign phase_end = (phase == PWD'(STEPS - 1));

  always_comb begin
    if (int'(phase) <= Q)          tri_v = int'(phase);
    else if (int'(phase) <= 3 * Q) tri_v = 2 * Q - int'(phase);
    else                           tri_v = int'(phase) - 4 * Q;
    off_v = (int'(period_i) * 3 * tri_v) / DEN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_cnt <= '0;
      phase    <= '0;
      offset_o <= '0;
    end else if (!en_i) begin
      step_cnt <= '0;
      phase    <= '0;
      offset_o <= '0;
    end else begin
      offset_o <= PW'(off_v);
      if (step_end) begin
        step_cnt <= '0;
        phase    <= phase_end ? '0 : phase + PWD'(1);
      end else begin
        step_cnt <= step_cnt + SW'(1);
      end
    end
  end
endmodule

// File: rtl/sync_ss_sel.sv
module sync_ss_sel #(
  parameter int PW        = 12,
  parameter int WIN_CYC   = 2000,
  parameter int MIN_EDGES = 4,
  parameter int MAX_EDGES = 36,
  parameter int HOLD_CYC  = 32000,
  parameter int MOD_CYC   = 125000,
  parameter int STEPS     = 100
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sync_i,
  input  logic [PW-1:0]        period_i,
  output logic                 ext_sync_o,
  output logic                 spread_en_o,
  output logic signed [PW-1:0] offset_o
);
  logic level_w, win_done_w, win_ok_w;

  sync_rate_meter #(
    .WIN_CYC(WIN_CYC), .MIN_EDGES(MIN_EDGES), .MAX_EDGES(MAX_EDGES)
  ) u_meter (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(sync_i),
    .level_o(level_w), .win_done_o(win_done_w), .win_ok_o(win_ok_w)
  );

  sync_mode_ctrl #(.HOLD_CYC(HOLD_CYC)) u_mode (
    .clk_i(clk_i), .rst_ni(rst_ni), .level_i(level_w),
    .win_done_i(win_done_w), .win_ok_i(win_ok_w),
    .ext_o(ext_sync_o), .spread_o(spread_en_o)
  );

  spread_tri_gen #(.PW(PW), .MOD_CYC(MOD_CYC), .STEPS(STEPS)) u_tri (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(spread_en_o),
    .period_i(period_i), .offset_o(offset_o)
  );
endmodule

// File: rtl/sync_ss_sel_chk.sv
module sync_ss_sel_chk #(
  parameter int PW = 12
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 win_done_w,
  input logic [PW-1:0]        period_i,
  input logic                 ext_sync_o,
  input logic                 spread_en_o,
  input logic signed [PW-1:0] offset_o
);
  int mag, lim;
  always_comb begin
    mag = (offset_o < 0) ? -int'(offset_o) : int'(offset_o);
    lim = (int'(period_i) * 3) / 100;
  end

  // R4
  ext_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_sync_o |-> !spread_en_o);

  // R4
  ext_at_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ext_sync_o) |-> $past(win_done_w));

  // R7
  no_direct_spread_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(spread_en_o) |-> !$past(ext_sync_o));

  // R8
  offset_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !spread_en_o |=> offset_o == '0);

  // R9
  offset_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mag <= lim);
endmodule

bind sync_ss_sel sync_ss_sel_chk #(.PW(PW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .win_done_w(win_done_w),
  .period_i(period_i), .ext_sync_o(ext_sync_o),
  .spread_en_o(spread_en_o), .offset_o(offset_o)
);

// File: tb/sync_ss_sel_test.sv
`timescale 1ns/1ps
module sync_ss_sel_test;
  localparam int PW   = 12;
  localparam int WIN  = 2000;
  localparam int HOLD = 32000;
  localparam int MOD  = 8000;
  localparam int NV   = 7;
  // half period in ns (0 = static), static level, expected ext, expected spread
  localparam int V_HALF [NV] = '{0, 0, 500, 250, 1250, 100, 0};
  localparam bit V_LVL  [NV] = '{0, 1, 0, 0, 0, 0, 0};
  localparam bit V_EXT  [NV] = '{0, 0, 1, 1, 1, 0, 0};
  localparam bit V_SS   [NV] = '{0, 1, 0, 0, 0, 0, 0};

  logic clk = 0, rst_n = 0, sync_r = 0;
  logic [PW-1:0] period = 12'd1000;
  logic ext, ss;
  logic signed [PW-1:0] offset;
  int half_ns = 0;
  bit lvl = 0, done = 0;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  sync_ss_sel #(.PW(PW), .WIN_CYC(WIN), .MIN_EDGES(4), .MAX_EDGES(36),
    .HOLD_CYC(HOLD), .MOD_CYC(MOD), .STEPS(32)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync_r), .period_i(period),
    .ext_sync_o(ext), .spread_en_o(ss), .offset_o(offset));

  initial forever begin
    if (half_ns == 0) begin sync_r = lvl; #4; end
    else begin #(half_ns); sync_r = ~sync_r; end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int peak, t_prev, t_cur, maxv, minv, last;
    peak = (1000 * 3) / 100;
    cyc(3);
    chk("R1 ext", ext, 0); chk("R1 spread", ss, 0); chk("R1 offset", offset, 0);
    rst_n = 1;
    cyc(2);
    chk("R1 ext after release", ext, 0);

    for (int i = 0; i < NV; i++) begin
      half_ns = V_HALF[i]; lvl = V_LVL[i];
      cyc(4 * WIN);
      chk(V_HALF[i] > 0 ? (V_EXT[i] ? "R4 ext" : "R5 ext") : (V_LVL[i] ? "R3 ext" : "R2 ext"), ext, V_EXT[i]);
      chk(V_HALF[i] > 0 ? "R4 spread" : (V_LVL[i] ? "R3 spread" : "R2 spread"), ss, V_SS[i]);
      if (!V_SS[i]) chk("R8 offset idle", offset, 0);
    end

    // loss with pin resting low
    half_ns = 500; cyc(4 * WIN);
    chk("R4 ext before loss", ext, 1);
    half_ns = 0; lvl = 0; cyc(3 * WIN);
    chk("R6 ext", ext, 0); chk("R6 spread", ss, 0);

    // loss with pin resting high
    half_ns = 500; cyc(4 * WIN);
    chk("R4 ext before loss high", ext, 1);
    half_ns = 0; lvl = 1; cyc(3 * WIN);
    chk("R7 ext dropped", ext, 0); chk("R7 spread held", ss, 0);
    cyc(HOLD - 3 * WIN - 200);
    chk("R7 spread still held", ss, 0);
    chk("R8 offset during hold", offset, 0);
    cyc(2 * WIN + 400);
    chk("R7 spread after hold", ss, 1);

    // triangle shape and rate
    maxv = -1000; minv = 1000; t_prev = -1; t_cur = -1; last = offset;
    for (int c = 0; c < 2 * MOD + 500; c++) begin
      @(negedge clk);
      if (offset > maxv) maxv = offset;
      if (offset < minv) minv = offset;
      if (offset == peak && last != peak) begin t_prev = t_cur; t_cur = c; end
      last = offset;
    end
    chk("R9 positive peak", maxv, peak);
    chk("R9 negative peak", minv, -peak);
    chk("R10 modulation period", t_cur - t_prev, MOD);

    // R9 scaling with a different period code
    period = 12'd2000;
    cyc(MOD);
    chk("R9 offset bound", (offset < 0 ? -offset : offset) <= 60, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule